// File: doc/BRIEF.md
# Floating-Point Minimum/Maximum Selector

This unit picks one of two IEEE-754 operands according to a selectable rule: the signed minimum, the signed maximum, the operand of smaller magnitude, or the operand of larger magnitude. A runtime format bit chooses between 32-bit and 64-bit operands. NaN inputs are handled with the 2008 minNum/maxNum rules, so a single quiet NaN is suppressed in favour of the number. An invalid-operation flag is produced for the floating-point status register. Subnormal values take part by their true value and are never flushed.

The unit is registered. Operands presented with `in_valid` in one cycle produce `out_valid` and the result on the next rising edge. When the core runs an older instruction-set revision, the same operation codes belong to legacy reciprocal step operations. In that case the unit raises an unimplemented flag and does not compute a result.

Top module: `fp_minmax`

## Requirements
- R1: With `in_op` = 2'b00 (signed minimum), the result is the operand with the smaller signed value.
- R2: With `in_op` = 2'b10 (signed maximum), the result is the operand with the larger signed value.
- R3: With `in_op` = 2'b01 (magnitude minimum), the operand with the smaller absolute value is returned with its own sign unchanged.
- R4: With `in_op` = 2'b11 (magnitude maximum), the operand with the larger absolute value is returned with its own sign unchanged.
- R5: When the magnitudes are equal, the magnitude minimum returns the signed minimum and the magnitude maximum returns the signed maximum (for example -3 and +3 give -3 and +3).
- R6: Negative zero ranks below positive zero: the signed minimum of +0 and -0 is -0, and the signed maximum is +0.
- R7: When exactly one operand is a quiet NaN (exponent all ones, fraction nonzero, top fraction bit 1) and neither is signaling, the other operand is returned and `out_invalid` stays 0.
- R8: When both operands are NaN, or either is a signaling NaN (top fraction bit 0), the result is the default quiet NaN and `out_invalid` is 1. In single format the default quiet NaN is 0x7FC00000. In double format it is 0x7FF8000000000000.
- R9: With `in_dbl` = 0, only bits 31:0 of each operand are used, and bits 63:32 of the result are 0.
- R10: Subnormal operands are ordered by their value and are returned unchanged.
- R11: With `rev6_ok` = 0, `out_unimpl` is 1, `out_invalid` is 0 and the result is 0 for every operation code.
- R12: The outputs update one clock after `in_valid`. `out_valid` is high exactly in the cycle after an accepted input. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and operation are presented this cycle |
| in_dbl | input | 1 | 1 = 64-bit format, 0 = 32-bit format |
| in_op | input | 2 | bit 1: maximum when set; bit 0: compare magnitudes when set |
| rev6_ok | input | 1 | 1 when the core implements the newer revision with these operations |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| out_valid | output | 1 | Result is valid this cycle |
| out_result | output | 64 | Chosen operand or default NaN |
| out_invalid | output | 1 | Invalid-operation exception flag |
| out_unimpl | output | 1 | Operation not implemented on this revision |

## Verification
The hardest situations to reach from the ports are magnitude ties between operands of opposite sign, and the meeting of signaling NaNs with subnormals and signed zeros. Uniform random bit patterns almost never produce these. The stimulus therefore draws each operand from a weighted pool of classes: random bits, signed zeros, infinities, quiet and signaling NaNs, subnormals, and a copy of the other operand with its sign flipped. This produces ties, NaN pairs and zero pairs often in both formats. Directed cases pin down each encoding.

// File: rtl/fpmm_pkg.sv
`timescale 1ns/1ps
package fpmm_pkg;
    parameter int unsigned WORD_W   = 64;
    parameter int unsigned SP_EXP_W = 8;
    parameter int unsigned SP_MAN_W = 23;
    parameter int unsigned DP_EXP_W = 11;
    parameter int unsigned DP_MAN_W = 52;
    localparam int unsigned SP_W    = SP_EXP_W + SP_MAN_W + 1;
    localparam int unsigned MAG_W   = WORD_W - 1;

    // default quiet NaN: exponent all ones plus the top fraction bit
    localparam logic [WORD_W-1:0] SP_QNAN =
        ((WORD_W'(1) << (SP_EXP_W + 1)) - WORD_W'(1)) << (SP_MAN_W - 1);
    localparam logic [WORD_W-1:0] DP_QNAN =
        ((WORD_W'(1) << (DP_EXP_W + 1)) - WORD_W'(1)) << (DP_MAN_W - 1);

    // bit 1 selects maximum, bit 0 selects magnitude comparison
    typedef enum logic [1:0] {
        OP_MIN  = 2'b00,
        OP_MINA = 2'b01,
        OP_MAX  = 2'b10,
        OP_MAXA = 2'b11
    } mm_op_e;

    typedef struct packed {
        logic             sign;
        logic             nan;
        logic             snan;
        logic [MAG_W-1:0] mag;
    } opnd_t;

    typedef struct packed {
        logic              vld;
        logic              dbl;
        logic              invalid;
        logic              unimpl;
        logic [WORD_W-1:0] res;
    } out_t;
endpackage

// File: rtl/fpmm_classify.sv
`timescale 1ns/1ps
module fpmm_classify
    import fpmm_pkg::*;
#(
    parameter int unsigned EXP_W = 8,
    parameter int unsigned MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] bits_i,
    output opnd_t                info_o
);
    localparam int unsigned TOP = EXP_W + MAN_W;

    logic exp_ones;
    logic frac_nz;

    always_comb begin
        exp_ones      = &bits_i[TOP-1:MAN_W];
        frac_nz       = |bits_i[MAN_W-1:0];
        info_o        = '0;
        info_o.sign   = bits_i[TOP];
        info_o.nan    = exp_ones & frac_nz;
        info_o.snan   = exp_ones & frac_nz & ~bits_i[MAN_W-1];
        info_o.mag[TOP-1:0] = bits_i[TOP-1:0];
    end
endmodule

// File: rtl/fpmm_order.sv
`timescale 1ns/1ps
module fpmm_order
    import fpmm_pkg::*;
(
    input  opnd_t  a_i,
    input  opnd_t  b_i,
    input  mm_op_e op_i,
    output logic   take_b_o,
    output logic   bad_o
);
    logic mag_lt;
    logic mag_gt;
    logic mag_eq;
    logic a_below;
    logic b_below;
    logic num_take_b;

    always_comb begin
        mag_lt = a_i.mag < b_i.mag;
        mag_gt = a_i.mag > b_i.mag;
        mag_eq = !mag_lt && !mag_gt;

        // signed ordering; -0 ranks below +0 through the sign test
        if (a_i.sign != b_i.sign) begin
            a_below = a_i.sign;
            b_below = b_i.sign;
        end else if (!a_i.sign) begin
            a_below = mag_lt;
            b_below = mag_gt;
        end else begin
            a_below = mag_gt;
            b_below = mag_lt;
        end

        unique case (op_i)
            OP_MIN:  num_take_b = b_below;
            OP_MAX:  num_take_b = a_below;
            OP_MINA: num_take_b = mag_gt || (mag_eq && b_below);
            OP_MAXA: num_take_b = mag_lt || (mag_eq && a_below);
            default: num_take_b = 1'b0;
        endcase

        bad_o = a_i.snan || b_i.snan || (a_i.nan && b_i.nan);
        if (a_i.nan)      take_b_o = 1'b1;
        else if (b_i.nan) take_b_o = 1'b0;
        else              take_b_o = num_take_b;
    end
endmodule

// File: rtl/fpmm_assemble.sv
`timescale 1ns/1ps
module fpmm_assemble
    import fpmm_pkg::*;
(
    input  logic              dbl_i,
    input  logic              bad_i,
    input  logic              take_b_i,
    input  logic              unimpl_i,
    input  logic [WORD_W-1:0] a_word_i,
    input  logic [WORD_W-1:0] b_word_i,
    output logic [WORD_W-1:0] res_o,
    output logic              invalid_o
);
    always_comb begin
        invalid_o = 1'b0;
        if (unimpl_i) begin
            res_o = '0;
        end else if (bad_i) begin
            res_o     = dbl_i ? DP_QNAN : SP_QNAN;
            invalid_o = 1'b1;
        end else begin
            res_o = take_b_i ? b_word_i : a_word_i;
        end
    end
endmodule

// File: rtl/fp_minmax.sv
`timescale 1ns/1ps
module fp_minmax
    import fpmm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_dbl,
    input  logic [1:0]        in_op,
    input  logic              rev6_ok,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_result,
    output logic              out_invalid,
    output logic              out_unimpl
);
    localparam int unsigned N_OPND = 2;

    logic [WORD_W-1:0] raw_w  [N_OPND];
    logic [WORD_W-1:0] used_w [N_OPND];
    opnd_t             sp_info[N_OPND];
    opnd_t             dp_info[N_OPND];
    opnd_t             sel_info[N_OPND];

    logic              take_b;
    logic              bad;
    logic [WORD_W-1:0] res_c;
    logic              inv_c;
    out_t              st_d;
    out_t              st_q;

    assign raw_w[0] = opa;
    assign raw_w[1] = opb;

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        fpmm_classify #(.EXP_W(SP_EXP_W), .MAN_W(SP_MAN_W)) u_sp (
            .bits_i (raw_w[g][SP_W-1:0]),
            .info_o (sp_info[g])
        );
        fpmm_classify #(.EXP_W(DP_EXP_W), .MAN_W(DP_MAN_W)) u_dp (
            .bits_i (raw_w[g]),
            .info_o (dp_info[g])
        );
        assign sel_info[g] = in_dbl ? dp_info[g] : sp_info[g];
        assign used_w[g]   = in_dbl ? raw_w[g]
                                    : {{(WORD_W-SP_W){1'b0}}, raw_w[g][SP_W-1:0]};
    end

    fpmm_order u_order (
        .a_i      (sel_info[0]),
        .b_i      (sel_info[1]),
        .op_i     (mm_op_e'(in_op)),
        .take_b_o (take_b),
        .bad_o    (bad)
    );

    fpmm_assemble u_asm (
        .dbl_i     (in_dbl),
        .bad_i     (bad),
        .take_b_i  (take_b),
        .unimpl_i  (!rev6_ok),
        .a_word_i  (used_w[0]),
        .b_word_i  (used_w[1]),
        .res_o     (res_c),
        .invalid_o (inv_c)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.dbl     = in_dbl;
            st_d.unimpl  = !rev6_ok;
            st_d.invalid = inv_c;
            st_d.res     = res_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid   = st_q.vld;
    assign out_result  = st_q.res;
    assign out_invalid = st_q.invalid;
    assign out_unimpl  = st_q.unimpl;

    // R12: one-cycle latency of the valid strobe
    a_r12_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r12_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R11: older revision yields only the unimplemented flag
    a_r11_unimpl: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !rev6_ok) |=> (out_unimpl && !out_invalid && out_result == '0));

    // R9: single-format results carry zero upper bits
    a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !st_q.dbl) |-> (out_result[WORD_W-1:SP_W] == '0));

    // R8: an invalid result is always the default quiet NaN of its format
    a_r8_default_nan: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_invalid) |-> (out_result == (st_q.dbl ? DP_QNAN : SP_QNAN)));

    // R7: a valid non-invalid result is one of the two operands
    a_r7_is_operand: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rev6_ok) |=> (out_invalid
            || out_result == $past(used_w[0]) || out_result == $past(used_w[1])));
endmodule

// File: tb/sim_fp_minmax.sv
`timescale 1ns/1ps
module sim_fp_minmax;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_dbl = 1'b0;
    logic [1:0]  in_op = 2'b00;
    logic        rev6_ok = 1'b1;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_invalid;
    logic        out_unimpl;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    localparam logic [63:0] SQ = 64'h0000_0000_7FC0_0000;
    localparam logic [63:0] DQ = 64'h7FF8_0000_0000_0000;

    always #10 clk = ~clk;

    fp_minmax u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dbl(in_dbl),
        .in_op(in_op), .rev6_ok(rev6_ok), .opa(opa), .opb(opb),
        .out_valid(out_valid), .out_result(out_result),
        .out_invalid(out_invalid), .out_unimpl(out_unimpl)
    );

    // reference: {unimpl, invalid, result}
    function automatic logic [65:0] ref_model(input logic [1:0] op, input logic dbl,
                                              input logic [63:0] a, input logic [63:0] b,
                                              input logic newisa);
        logic [63:0] wa, wb;
        logic sa, sb, na, nb, qa, qb;
        logic [62:0] ma, mb;
        logic signed [64:0] ka, kb;
        logic a_lt, b_lt, pick_b;
        if (!newisa) return {1'b1, 1'b0, 64'd0};
        wa = dbl ? a : {32'd0, a[31:0]};
        wb = dbl ? b : {32'd0, b[31:0]};
        if (dbl) begin
            sa = wa[63]; sb = wb[63]; ma = wa[62:0]; mb = wb[62:0];
            na = (wa[62:52] == 11'h7FF) && (wa[51:0] != 0);
            nb = (wb[62:52] == 11'h7FF) && (wb[51:0] != 0);
            qa = wa[51]; qb = wb[51];
        end else begin
            sa = wa[31]; sb = wb[31]; ma = {32'd0, wa[30:0]}; mb = {32'd0, wb[30:0]};
            na = (wa[30:23] == 8'hFF) && (wa[22:0] != 0);
            nb = (wb[30:23] == 8'hFF) && (wb[22:0] != 0);
            qa = wa[22]; qb = wb[22];
        end
        if ((na && !qa) || (nb && !qb) || (na && nb))
            return {1'b0, 1'b1, dbl ? DQ : SQ};
        if (na) return {2'b00, wb};
        if (nb) return {2'b00, wa};
        ka = sa ? -$signed({2'b00, ma}) : $signed({2'b00, ma});
        kb = sb ? -$signed({2'b00, mb}) : $signed({2'b00, mb});
        a_lt = (ka < kb) || (ka == kb && sa && !sb);
        b_lt = (kb < ka) || (ka == kb && sb && !sa);
        case (op)
            2'b00: pick_b = b_lt;
            2'b10: pick_b = a_lt;
            2'b01: pick_b = (mb < ma) || (mb == ma && b_lt);
            default: pick_b = (ma < mb) || (mb == ma && a_lt);
        endcase
        return {2'b00, pick_b ? wb : wa};
    endfunction

    function automatic logic [63:0] pool_val(input logic dbl, input logic [63:0] other);
        logic [63:0] r;
        logic s;
        r = {$urandom, $urandom};
        s = r[5];
        case ($urandom % 9)
            0: return dbl ? {s, 63'd0} : {32'd0, s, 31'd0};
            1: return dbl ? {s, 11'h7FF, 52'd0} : {32'd0, s, 8'hFF, 23'd0};
            2: return dbl ? {s, 11'h7FF, 1'b1, r[50:0]} : {32'd0, s, 8'hFF, 1'b1, r[21:0]};
            3: return dbl ? {s, 11'h7FF, 1'b0, r[50:1], 1'b1} : {32'd0, s, 8'hFF, 1'b0, r[21:1], 1'b1};
            4: return dbl ? {s, 11'd0, r[51:0]} : {32'd0, s, 8'd0, r[22:0]};
            5: return dbl ? {~other[63], other[62:0]} : {r[63:32], ~other[31], other[30:0]};
            6: return other;
            default: return r;
        endcase
    endfunction

    task automatic run_op(input logic [1:0] op, input logic dbl, input logic [63:0] a,
                          input logic [63:0] b, input logic newisa,
                          input logic [65:0] expv, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_dbl = dbl; opa = a; opb = b; rev6_ok = newisa;
        @(negedge clk);
        in_valid = 1'b0;
        checks++;
        if (!out_valid || {out_unimpl, out_invalid, out_result} !== expv) begin
            errors++;
            $display("FAIL %s: op=%0d dbl=%0d a=%h b=%h got v=%0d u=%0d i=%0d r=%h exp u=%0d i=%0d r=%h",
                     tag, op, dbl, a, b, out_valid, out_unimpl, out_invalid, out_result,
                     expv[65], expv[64], expv[63:0]);
        end
    endtask

    function automatic string op_tag(input logic [1:0] op);
        case (op)
            2'b00: return "R1";
            2'b10: return "R2";
            2'b01: return "R3";
            default: return "R4";
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R12: reset state
        checks++;
        if ({out_valid, out_invalid, out_unimpl} !== 3'b000 || out_result !== 64'd0) begin
            errors++;
            $display("FAIL R12 reset: got v=%0d i=%0d u=%0d r=%h exp all zero",
                     out_valid, out_invalid, out_unimpl, out_result);
        end
        rst_n = 1'b1;
        @(negedge clk);

        run_op(2'b00, 1'b0, 64'h3F80_0000, 64'h4000_0000, 1'b1, {2'b00, 64'h3F80_0000}, "R1");
        run_op(2'b00, 1'b1, 64'h4014_0000_0000_0000, 64'hC014_0000_0000_0000, 1'b1,
               {2'b00, 64'hC014_0000_0000_0000}, "R1");
        run_op(2'b10, 1'b1, 64'h3FF0_0000_0000_0000, 64'hC014_0000_0000_0000, 1'b1,
               {2'b00, 64'h3FF0_0000_0000_0000}, "R2");
        run_op(2'b01, 1'b0, 64'hBF80_0000, 64'h4000_0000, 1'b1, {2'b00, 64'hBF80_0000}, "R3");
        run_op(2'b11, 1'b1, 64'hC020_0000_0000_0000, 64'h4008_0000_0000_0000, 1'b1,
               {2'b00, 64'hC020_0000_0000_0000}, "R4");
        run_op(2'b01, 1'b0, 64'h4040_0000, 64'hC040_0000, 1'b1, {2'b00, 64'hC040_0000}, "R5");
        run_op(2'b11, 1'b0, 64'hC040_0000, 64'h4040_0000, 1'b1, {2'b00, 64'h4040_0000}, "R5");
        run_op(2'b00, 1'b1, 64'h0, 64'h8000_0000_0000_0000, 1'b1,
               {2'b00, 64'h8000_0000_0000_0000}, "R6");
        run_op(2'b10, 1'b0, 64'h8000_0000, 64'h0, 1'b1, {2'b00, 64'h0}, "R6");
        run_op(2'b00, 1'b0, 64'h7FC0_0001, 64'h3F80_0000, 1'b1, {2'b00, 64'h3F80_0000}, "R7");
        run_op(2'b11, 1'b1, 64'h4000_0000_0000_0000, 64'hFFF8_0000_0000_0001, 1'b1,
               {2'b00, 64'h4000_0000_0000_0000}, "R7");
        run_op(2'b10, 1'b0, 64'h7F80_0001, 64'h3F80_0000, 1'b1, {2'b01, SQ}, "R8");
        run_op(2'b00, 1'b1, 64'h7FF8_0000_0000_0005, 64'hFFF8_0000_0000_0000, 1'b1,
               {2'b01, DQ}, "R8");
        run_op(2'b01, 1'b1, 64'h3FF0_0000_0000_0000, 64'h7FF0_0000_0000_0001, 1'b1,
               {2'b01, DQ}, "R8");
        run_op(2'b10, 1'b0, 64'hDEAD_BEEF_3F80_0000, 64'h1234_5678_4000_0000, 1'b1,
               {2'b00, 64'h4000_0000}, "R9");
        run_op(2'b10, 1'b0, 64'h0000_0001, 64'h0000_0002, 1'b1, {2'b00, 64'h0000_0002}, "R10");
        run_op(2'b00, 1'b1, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0000, 1'b1,
               {2'b00, 64'h8000_0000_0000_0001}, "R10");
        run_op(2'b01, 1'b1, 64'h0000_0000_0000_0003, 64'h8010_0000_0000_0000, 1'b1,
               {2'b00, 64'h0000_0000_0000_0003}, "R10");
        run_op(2'b11, 1'b0, 64'h7F80_0001, 64'h3F80_0000, 1'b0, {2'b10, 64'h0}, "R11");
        run_op(2'b00, 1'b1, 64'h1, 64'h2, 1'b0, {2'b10, 64'h0}, "R11");

        // R12: valid strobe falls one cycle after in_valid is dropped
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R12 valid drop: got %0d exp 0", out_valid);
        end

        for (int i = 0; i < 600; i++) begin
            logic [1:0]  op;
            logic        dbl;
            logic [63:0] a, b;
            op  = 2'($urandom);
            dbl = 1'($urandom);
            a   = pool_val(dbl, {$urandom, $urandom});
            b   = pool_val(dbl, a);
            if ($urandom % 2) begin
                logic [63:0] t;
                t = a; a = b; b = t;
            end
            run_op(op, dbl, a, b, 1'b1, ref_model(op, dbl, a, b, 1'b1), op_tag(op));
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got hang exp completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule